// File: doc/BRIEF.md
# Line Guard Detector with Per-Line Tag

This block sits beside a direct-mapped instruction cache and tells a sequential prefetcher whether a cache line ends a prefetch run. A line is a packed group of instruction words. A word marks the end of a run only when two opcode bits say it is a control transfer and a third, fixed bit (the guard) is set. When a line is refilled into the cache, the block decodes all words of that line in a single cycle. It ORs the per-word results together and reports the outcome.

The block keeps one tag bit per cache set, which spares the cache a wide read port. The same bit serves two meanings, chosen by the page-mode bit that comes with each request from the translation lookaside buffer. When the page-mode bit is set, the bit holds the decoded guard result. When it is clear, the bit holds the ordinary tagged-prefetch mark, which says that the line was brought in by a prefetch. A later probe of the set returns the stored bit with no extra decode. Every request produces one registered result, one cycle after the request.

A small result state machine has three states. `ST_IDLE` means there is no result. `ST_FILL_DONE` reports a refill. `ST_PROBE_DONE` reports a probe. From any state, the machine takes transition `T_FILL` to `ST_FILL_DONE` when `fill_req` is high. When `fill_req` is low and `probe_req` is high, it takes `T_PROBE` to `ST_PROBE_DONE`. With neither request, it takes `T_REST` to `ST_IDLE`.

Top module: `guard_line_detector`

## Requirements
- R1: After reset `res_valid`, `res_guard` and `res_pf_tag` are 0, and every set's tag bit is 0, so a probe of any set returns 0 on both flags.
- R2: A word is an end marker only when its bits 31, 30 and 29 are all 1 (bits 31:30 = 2'b11 mark a control transfer, bit 29 is the guard). A word with only the opcode bits, or only the guard bit, is not a marker.
- R3: Word k of a line occupies line bits [32k+31:32k], with k from 0 to 7. The line result is 1 when any word in any position is a marker.
- R4: A refill request gives `res_valid`=1 and `res_kind`=0 in the next cycle, with `res_index` equal to the refill index.
- R5: A refill with the page-mode bit set stores the line result in the set's tag and reports it on `res_guard`, with `res_pf_tag`=0.
- R6: A refill with the page-mode bit clear stores `fill_prefetched` in the tag and reports it on `res_pf_tag`, with `res_guard`=0, whatever the line contains.
- R7: A probe gives `res_valid`=1 and `res_kind`=1 in the next cycle, with the set index echoed. `res_guard` is the tag AND the probe's page-mode bit, and `res_pf_tag` is the tag AND NOT that bit.
- R8: When a refill and a probe arrive in the same cycle, only the refill is reported and the probe is dropped.
- R9: A later refill of a set overwrites its tag, so a set can go from 1 back to 0.
- R10: A probe in the cycle right after a refill of the same set returns the value that refill wrote.
- R11: A cycle with no request gives `res_valid`=0 in the next cycle.
- R12: `res_guard` and `res_pf_tag` are never high together, and both are 0 while `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_req | input | 1 | A line is being refilled this cycle |
| fill_index | input | 6 | Set index of the refill |
| fill_line | input | 256 | Refilled line, 8 words of 32 bits |
| fill_guard_page | input | 1 | Page-mode bit of the refill (1 = guard meaning) |
| fill_prefetched | input | 1 | Refill was issued by a prefetch |
| probe_req | input | 1 | Probe of a set this cycle |
| probe_index | input | 6 | Set index of the probe |
| probe_guard_page | input | 1 | Page-mode bit of the probe |
| res_valid | output | 1 | Result present |
| res_kind | output | 1 | 0 = refill result, 1 = probe result |
| res_guard | output | 1 | End-of-run guard found |
| res_pf_tag | output | 1 | Ordinary tagged-prefetch mark |
| res_index | output | 6 | Set index of the result |

## Verification
Every result is due exactly one clock after the request that caused it: one register lies between a request and the result outputs. The driver raises a request just after a falling edge. It pushes the expected result into the scoreboard after the next rising edge. The monitor compares at the falling edge that follows. A result that arrives early, arrives late or is missing shows up as a mismatch against the queue. Idle cycles are checked for a low `res_valid` at the same offset.

// File: rtl/gsd_pkg.sv
package gsd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_FILL_DONE  = 2'd1,
        ST_PROBE_DONE = 2'd2
    } res_state_e;

    typedef enum logic {
        KIND_FILL  = 1'b0,
        KIND_PROBE = 1'b1
    } res_kind_e;

endpackage

// File: rtl/gsd_slot_decode.sv
// One instruction word: end-of-run marker test on three fixed bits.
module gsd_slot_decode (
    input  logic ct_hi,
    input  logic ct_lo,
    input  logic guard,
    output logic end_mark
);
    assign end_mark = ct_hi & ct_lo & guard;
endmodule

// File: rtl/gsd_line_scan.sv
// Whole-line scan: every word decoded in parallel, results ORed.
module gsd_line_scan #(
    parameter int SLOTS     = 8,
    parameter int SLOT_W    = 32,
    parameter int CT_BIT_HI = 31,
    parameter int CT_BIT_LO = 30,
    parameter int GUARD_BIT = 29,
    localparam int LINE_W   = SLOTS * SLOT_W
) (
    input  logic [LINE_W-1:0] line,
    output logic              found
);
    logic [SLOTS-1:0] slot_hit;
    logic             unused_line_bits;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        gsd_slot_decode u_dec (
            .ct_hi    (line[s*SLOT_W + CT_BIT_HI]),
            .ct_lo    (line[s*SLOT_W + CT_BIT_LO]),
            .guard    (line[s*SLOT_W + GUARD_BIT]),
            .end_mark (slot_hit[s])
        );
    end

    assign found            = |slot_hit;
    assign unused_line_bits = ^line;
endmodule

// File: rtl/gsd_tag_store.sv
// One tag bit per direct-mapped set, written with the fill.
module gsd_tag_store #(
    parameter int SETS    = 64,
    localparam int IDX_W  = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_bit,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit
);
    logic [SETS-1:0] tag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= '0;
        end else if (wr_en) begin
            tag_q[wr_idx] <= wr_bit;
        end
    end

    assign rd_bit = tag_q[rd_idx];
endmodule

// File: rtl/gsd_result_fsm.sv
// Result sequencer: fill beats probe; one registered result per request.
module gsd_result_fsm
    import gsd_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_req,
    input  logic [IDX_W-1:0] fill_index,
    input  logic             fill_guard_page,
    input  logic             fill_tag_bit,
    input  logic             probe_req,
    input  logic [IDX_W-1:0] probe_index,
    input  logic             probe_guard_page,
    input  logic             probe_tag_bit,
    output logic             res_valid,
    output logic             res_kind,
    output logic             res_guard,
    output logic             res_pf_tag,
    output logic [IDX_W-1:0] res_index
);
    res_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             bit_q;
    logic             page_q;

    // next state: T_FILL, T_PROBE, T_REST
    always_comb begin
        if (fill_req) begin
            state_d = ST_FILL_DONE;
        end else if (probe_req) begin
            state_d = ST_PROBE_DONE;
        end else begin
            state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            bit_q  <= 1'b0;
            page_q <= 1'b0;
        end else if (fill_req) begin
            idx_q  <= fill_index;
            bit_q  <= fill_tag_bit;
            page_q <= fill_guard_page;
        end else if (probe_req) begin
            idx_q  <= probe_index;
            bit_q  <= probe_tag_bit;
            page_q <= probe_guard_page;
        end
    end

    always_comb begin
        res_valid  = 1'b0;
        res_kind   = KIND_FILL;
        res_guard  = 1'b0;
        res_pf_tag = 1'b0;
        res_index  = '0;
        unique case (state_q)
            ST_IDLE: begin
                res_valid = 1'b0;
            end
            ST_FILL_DONE: begin
                res_valid  = 1'b1;
                res_kind   = KIND_FILL;
                res_guard  = page_q & bit_q;
                res_pf_tag = ~page_q & bit_q;
                res_index  = idx_q;
            end
            ST_PROBE_DONE: begin
                res_valid  = 1'b1;
                res_kind   = KIND_PROBE;
                res_guard  = page_q & bit_q;
                res_pf_tag = ~page_q & bit_q;
                res_index  = idx_q;
            end
            default: begin
                res_valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/guard_line_detector.sv
module guard_line_detector #(
    parameter int SLOTS     = 8,
    parameter int SLOT_W    = 32,
    parameter int SETS      = 64,
    parameter int CT_BIT_HI = 31,
    parameter int CT_BIT_LO = 30,
    parameter int GUARD_BIT = 29,
    localparam int LINE_W   = SLOTS * SLOT_W,
    localparam int IDX_W    = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_req,
    input  logic [IDX_W-1:0]  fill_index,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              fill_guard_page,
    input  logic              fill_prefetched,
    input  logic              probe_req,
    input  logic [IDX_W-1:0]  probe_index,
    input  logic              probe_guard_page,
    output logic              res_valid,
    output logic              res_kind,
    output logic              res_guard,
    output logic              res_pf_tag,
    output logic [IDX_W-1:0]  res_index
);
    logic line_found;
    logic fill_tag_bit;
    logic probe_tag_bit;

    gsd_line_scan #(
        .SLOTS     (SLOTS),
        .SLOT_W    (SLOT_W),
        .CT_BIT_HI (CT_BIT_HI),
        .CT_BIT_LO (CT_BIT_LO),
        .GUARD_BIT (GUARD_BIT)
    ) u_scan (
        .line  (fill_line),
        .found (line_found)
    );

    // tag meaning follows the page-mode bit
    assign fill_tag_bit = fill_guard_page ? line_found : fill_prefetched;

    gsd_tag_store #(
        .SETS (SETS)
    ) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (fill_req),
        .wr_idx (fill_index),
        .wr_bit (fill_tag_bit),
        .rd_idx (probe_index),
        .rd_bit (probe_tag_bit)
    );

    gsd_result_fsm #(
        .IDX_W (IDX_W)
    ) u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .fill_req         (fill_req),
        .fill_index       (fill_index),
        .fill_guard_page  (fill_guard_page),
        .fill_tag_bit     (fill_tag_bit),
        .probe_req        (probe_req),
        .probe_index      (probe_index),
        .probe_guard_page (probe_guard_page),
        .probe_tag_bit    (probe_tag_bit),
        .res_valid        (res_valid),
        .res_kind         (res_kind),
        .res_guard        (res_guard),
        .res_pf_tag       (res_pf_tag),
        .res_index        (res_index)
    );
endmodule

// File: rtl/gsd_checker.sv
module gsd_checker #(
    parameter int LINE_W = 256,
    parameter int IDX_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fill_req,
    input logic [IDX_W-1:0]  fill_index,
    input logic [LINE_W-1:0] fill_line,
    input logic              fill_guard_page,
    input logic              fill_prefetched,
    input logic              probe_req,
    input logic [IDX_W-1:0]  probe_index,
    input logic              probe_guard_page,
    input logic              res_valid,
    input logic              res_kind,
    input logic              res_guard,
    input logic              res_pf_tag,
    input logic [IDX_W-1:0]  res_index
);
    p_fill_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |=> (res_valid && !res_kind && res_index == $past(fill_index)));

    p_probe_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_req && !fill_req) |=> (res_valid && res_kind && res_index == $past(probe_index)));

    p_fill_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_req && fill_req) |=> !res_kind);

    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_req && !probe_req) |=> !res_valid);

    p_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_guard && res_pf_tag));

    p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_guard && !res_pf_tag));

    p_plain_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_guard_page) |=> (!res_guard && res_pf_tag == $past(fill_prefetched)));

    p_empty_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && fill_guard_page && fill_line == '0) |=> !res_guard);

    p_fill_then_probe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_req && !fill_req && probe_guard_page && $past(fill_req)
         && $past(fill_guard_page) && probe_index == $past(fill_index))
        |=> (res_guard == $past(res_guard)));
endmodule

bind guard_line_detector gsd_checker #(
    .LINE_W (LINE_W),
    .IDX_W  (IDX_W)
) u_gsd_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .fill_req         (fill_req),
    .fill_index       (fill_index),
    .fill_line        (fill_line),
    .fill_guard_page  (fill_guard_page),
    .fill_prefetched  (fill_prefetched),
    .probe_req        (probe_req),
    .probe_index      (probe_index),
    .probe_guard_page (probe_guard_page),
    .res_valid        (res_valid),
    .res_kind         (res_kind),
    .res_guard        (res_guard),
    .res_pf_tag       (res_pf_tag),
    .res_index        (res_index)
);

// File: tb/tb_guard_line_detector.sv
`timescale 1ns/1ps
module tb_guard_line_detector;
    localparam int SLOTS  = 8;
    localparam int SLOT_W = 32;
    localparam int SETS   = 64;
    localparam int LINE_W = SLOTS * SLOT_W;
    localparam int IDX_W  = 6;

    typedef struct {
        logic       kind;
        logic       guard;
        logic       pf;
        logic [5:0] idx;
        string      req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fill_req = 1'b0;
    logic [IDX_W-1:0]  fill_index = '0;
    logic [LINE_W-1:0] fill_line = '0;
    logic              fill_guard_page = 1'b0;
    logic              fill_prefetched = 1'b0;
    logic              probe_req = 1'b0;
    logic [IDX_W-1:0]  probe_index = '0;
    logic              probe_guard_page = 1'b0;
    logic              res_valid, res_kind, res_guard, res_pf_tag;
    logic [IDX_W-1:0]  res_index;

    exp_t     sb[$];
    logic     mtag [SETS];
    int       n_checks = 0;
    int       n_fail   = 0;
    logic     mon_en   = 1'b0;

    always #2 clk = ~clk;

    guard_line_detector dut (
        .clk(clk), .rst_n(rst_n),
        .fill_req(fill_req), .fill_index(fill_index), .fill_line(fill_line),
        .fill_guard_page(fill_guard_page), .fill_prefetched(fill_prefetched),
        .probe_req(probe_req), .probe_index(probe_index),
        .probe_guard_page(probe_guard_page),
        .res_valid(res_valid), .res_kind(res_kind), .res_guard(res_guard),
        .res_pf_tag(res_pf_tag), .res_index(res_index)
    );

    // marker: bits 31,30,29 of a word all set (R2), any of 8 words (R3)
    function automatic logic model_guard(input logic [LINE_W-1:0] ln);
        for (int s = 0; s < SLOTS; s++) begin
            if (ln[s*SLOT_W + 31] && ln[s*SLOT_W + 30] && ln[s*SLOT_W + 29]) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic logic [LINE_W-1:0] one_word(input int slot, input logic [31:0] w);
        logic [LINE_W-1:0] ln = '0;
        ln[slot*SLOT_W +: SLOT_W] = w;
        return ln;
    endfunction

    task automatic check(input string req, input logic ok, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // driver: one request cycle, then push the expected result
    task automatic drive(input string req, input logic f, input logic [5:0] fi,
                         input logic [LINE_W-1:0] fl, input logic fg, input logic fp,
                         input logic p, input logic [5:0] pi, input logic pg);
        exp_t e;
        logic v;
        @(negedge clk);
        fill_req = f; fill_index = fi; fill_line = fl;
        fill_guard_page = fg; fill_prefetched = fp;
        probe_req = p; probe_index = pi; probe_guard_page = pg;
        @(posedge clk);
        e.req = req;
        if (f) begin
            v = fg ? model_guard(fl) : fp;
            mtag[fi] = v;
            e.kind = 1'b0; e.guard = fg & v; e.pf = !fg & v; e.idx = fi;
            sb.push_back(e);
        end else if (p) begin
            v = mtag[pi];
            e.kind = 1'b1; e.guard = pg & v; e.pf = !pg & v; e.idx = pi;
            sb.push_back(e);
        end
    endtask

    task automatic fill(input string req, input logic [5:0] i, input logic [LINE_W-1:0] ln,
                        input logic g, input logic pf);
        drive(req, 1'b1, i, ln, g, pf, 1'b0, '0, 1'b0);
    endtask

    task automatic probe(input string req, input logic [5:0] i, input logic g);
        drive(req, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1, i, g);
    endtask

    task automatic idle_cycle();
        drive("R11", 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    endtask

    // monitor: compare at the falling edge after the result edge
    always @(negedge clk) begin
        if (mon_en) begin
            if (res_valid) begin
                if (sb.size() == 0) begin
                    check("R11", 1'b0, "unexpected res_valid", 64'(res_valid), 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.req,
                          res_kind == e.kind && res_guard == e.guard &&
                          res_pf_tag == e.pf && res_index == e.idx,
                          "{kind,guard,pf,idx}",
                          {52'd0, res_kind, res_guard, res_pf_tag, 3'd0, res_index},
                          {52'd0, e.kind, e.guard, e.pf, 3'd0, e.idx});
                end
            end else if (sb.size() != 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.req, 1'b0, "missing result", 64'(res_valid), 64'd1);
            end else begin
                check("R12", !res_guard && !res_pf_tag, "flags while idle",
                      {62'd0, res_guard, res_pf_tag}, 64'd0);
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        for (int i = 0; i < SETS; i++) mtag[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", !res_valid && !res_guard && !res_pf_tag, "outputs in reset",
              {61'd0, res_valid, res_guard, res_pf_tag}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", !res_valid, "res_valid after reset", 64'(res_valid), 64'd0);
        mon_en = 1'b1;

        // R1: every tag starts at 0
        probe("R1", 6'd0, 1'b1);
        probe("R1", 6'd37, 1'b0);
        probe("R1", 6'd63, 1'b1);

        // R2 / R3 / R5 guard-page fills
        fill("R2", 6'd3, '0, 1'b1, 1'b0);
        fill("R3", 6'd4, one_word(0, 32'hE000_0000), 1'b1, 1'b0);
        fill("R3", 6'd5, one_word(7, 32'hE123_4567), 1'b1, 1'b0);
        fill("R2", 6'd6, one_word(2, 32'hC000_0000) | one_word(4, 32'h2000_0000)
                         | one_word(6, 32'h6FFF_FFFF), 1'b1, 1'b1);
        fill("R5", 6'd7, one_word(3, 32'hFFFF_FFFF), 1'b1, 1'b0);
        idle_cycle();

        // R5 / R7: read back with both page meanings
        probe("R5", 6'd4, 1'b1);
        probe("R7", 6'd4, 1'b0);
        probe("R5", 6'd6, 1'b1);
        probe("R7", 6'd5, 1'b1);

        // R6: plain page stores the prefetch mark, not the decode
        fill("R6", 6'd10, one_word(1, 32'hE000_0000), 1'b0, 1'b0);
        fill("R6", 6'd11, '0, 1'b0, 1'b1);
        probe("R6", 6'd10, 1'b1);
        probe("R6", 6'd11, 1'b0);
        probe("R7", 6'd11, 1'b1);

        // R9: overwrite a set tag 1 -> 0
        fill("R9", 6'd4, one_word(5, 32'hC000_0001), 1'b1, 1'b0);
        probe("R9", 6'd4, 1'b1);

        // R10: back-to-back fill then probe of the same set
        fill("R10", 6'd20, one_word(6, 32'hE000_0000), 1'b1, 1'b0);
        probe("R10", 6'd20, 1'b1);
        fill("R10", 6'd20, '0, 1'b1, 1'b0);
        probe("R10", 6'd20, 1'b1);

        // R8: simultaneous requests, fill wins, probe dropped
        drive("R8", 1'b1, 6'd21, one_word(0, 32'hE000_0000), 1'b1, 1'b0, 1'b1, 6'd11, 1'b0);
        idle_cycle();
        idle_cycle();
        probe("R8", 6'd21, 1'b1);

        // mixed stream
        lfsr = 32'h1BAD_F00D;
        for (int it = 0; it < 60; it++) begin
            logic [LINE_W-1:0] ln;
            for (int s = 0; s < SLOTS; s++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                ln[s*SLOT_W +: SLOT_W] = (it % 3 == 0) ? (lfsr & 32'hDFFF_FFFF) : lfsr;
            end
            if (lfsr[3]) fill("R5", 6'(lfsr[13:8]), ln, lfsr[4], lfsr[5]);
            else         probe("R7", 6'(lfsr[13:8]), lfsr[4]);
            if (lfsr[6]) idle_cycle();
        end

        idle_cycle();
        idle_cycle();
        check("R11", sb.size() == 0, "scoreboard drained", 64'(sb.size()), 64'd0);
        mon_en = 1'b0;
        summary();
        $finish;
    end
endmodule